// File: doc/BRIEF.md
# Byte Shift and Rotate Unit with Selectable Fill

This block moves an 8-bit value left or right by zero to three bit positions in a single combinational step. A mode control chooses between two behaviours. In rotate mode, the bits pushed off one end come back in at the other end. In shift mode, those bits are lost, and the emptied positions are loaded from a one-bit fill input.

An enable input gates the whole unit. When enable is low, the output is all zeros. The block has no state, so the output follows the inputs directly. Because the fill bit is free, logical shifts and ones-filling shifts come from the same hardware.

Top module: `shift_rot_unit`

## Requirements
- R1: With the unit enabled and an amount of 0, `data_o` equals `data_i` for every setting of direction, mode and fill.
- R2: With `dir_right_i` = 0 (left), output bit i carries input bit i-N for every i >= N, where N is the value of `amt_i`.
- R3: With `dir_right_i` = 1 (right), output bit i carries input bit i+N for every i <= 7-N.
- R4: In shift mode (`rotate_i` = 0) moving left, the N lowest output bits, bits 0 to N-1, all equal `fill_i`.
- R5: In shift mode moving right, the N highest output bits, bits 7 down to 8-N, all equal `fill_i`.
- R6: In rotate mode (`rotate_i` = 1), the bits leaving one end enter at the other end. The output is a circular rotation of the input by N places, and `fill_i` has no effect on it.
- R7: With `en_i` = 0, `data_o` is 8'h00 regardless of every other input.
- R8: The unit has no clock and no storage. `data_o` settles to its new value within the same time step as an input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 8 | Value to be moved |
| amt_i | input | 2 | Number of places, 0 to 3 |
| dir_right_i | input | 1 | 1 = toward bit 0 (right), 0 = toward bit 7 (left) |
| rotate_i | input | 1 | 1 = wrap the bits that leave, 0 = drop them |
| fill_i | input | 1 | Value loaded into emptied positions in shift mode |
| en_i | input | 1 | 0 forces the output to zero |
| data_o | output | 8 | Result |

## Verification
The sweep covers every combination of data byte, amount, direction, mode, fill and enable. The expected value comes from a reference built with integer shifts and masks.

- Amount zero is applied with both fill values and both modes. This separates a true pass-through from a stage that leaks fill bits or wraps bits when it should do nothing.
- Data patterns that differ only at their end bits separate rotation from fill. A wrapped bit and a fill bit can only match by chance, and each byte is also run with the opposite fill.
- Enable-low vectors reuse every other input pattern. Any path that bypasses the gate therefore shows up as a nonzero output.

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
  parameter int WIDTH = 8,
  parameter int AMT_W = 2
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             dir_right_i,
  input  logic             rotate_i,
  input  logic             fill_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] data_o
);

  localparam int STAGES = AMT_W;

  logic [WIDTH-1:0] stage [0:STAGES];

  assign stage[0] = data_i;

  // Log-depth barrel: stage k moves by 2**k when amt_i[k] is set.
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [S-1:0]     wrap_l, wrap_r;
    logic [WIDTH-1:0] moved_l, moved_r;

    assign wrap_l  = rotate_i ? stage[k][WIDTH-1 -: S] : {S{fill_i}};
    assign wrap_r  = rotate_i ? stage[k][S-1:0]        : {S{fill_i}};
    assign moved_l = {stage[k][WIDTH-1-S:0], wrap_l};
    assign moved_r = {wrap_r, stage[k][WIDTH-1:S]};

    assign stage[k+1] = !amt_i[k]    ? stage[k] :
                        dir_right_i  ? moved_r  : moved_l;
  end

  assign data_o = en_i ? stage[STAGES] : '0;

  always_comb begin
    if (!$isunknown({data_i, amt_i, dir_right_i, rotate_i, fill_i, en_i})) begin
      AST_DISABLED_ZERO: assert (en_i || data_o == '0) else $error("gate leak"); // R7
      AST_ZERO_AMT_PASS: assert (!en_i || amt_i != '0 || data_o == data_i) else $error("pass"); // R1
      AST_ROT_KEEPS_ONES: assert (!en_i || !rotate_i || $countones(data_o) == $countones(data_i)) else $error("rot"); // R6
      AST_LEFT_FILL_LSB: assert (!en_i || rotate_i || dir_right_i || amt_i == '0 || data_o[0] == fill_i) else $error("lfill"); // R4
      AST_RIGHT_FILL_MSB: assert (!en_i || rotate_i || !dir_right_i || amt_i == '0 || data_o[WIDTH-1] == fill_i) else $error("rfill"); // R5
      AST_LEFT_TOP_BIT: assert (!en_i || dir_right_i || data_o[WIDTH-1] == data_i[WIDTH-1-amt_i]) else $error("lmove"); // R2
      AST_RIGHT_LOW_BIT: assert (!en_i || !dir_right_i || data_o[0] == data_i[amt_i]) else $error("rmove"); // R3
    end
  end

endmodule

// File: tb/shift_rot_unit_bench.sv
module shift_rot_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [7:0] data_i = '0;
  logic [1:0] amt_i = '0;
  logic       dir_right_i = 1'b0, rotate_i = 1'b0, fill_i = 1'b0, en_i = 1'b0;
  logic [7:0] data_o;
  int applied = 0, miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_rot_unit u_shift_rot_unit (
    .data_i(data_i), .amt_i(amt_i), .dir_right_i(dir_right_i),
    .rotate_i(rotate_i), .fill_i(fill_i), .en_i(en_i), .data_o(data_o)
  );

  function automatic logic [7:0] ref_out(int d, int a, bit r, bit rot, bit f, bit e);
    int v;
    if (!e) return 8'h00;
    if (a == 0) return d[7:0];
    if (rot) v = r ? ((d >> a) | (d << (8 - a))) : ((d << a) | (d >> (8 - a)));
    else if (r) v = (d >> a) | (f ? (8'hff << (8 - a)) : 0);
    else v = (d << a) | (f ? ((1 << a) - 1) : 0);
    return v[7:0];
  endfunction

  initial begin
    string tag;
    logic [7:0] exp;

    // R7: idle state with enable low
    @(negedge clk);
    #(CLK_PERIOD/4);
    applied++;
    if (data_o !== 8'h00) begin
      miscompares++;
      $display("FAIL R7 idle: got %h exp 00", data_o);
    end

    for (int e = 0; e < 2; e++)
      for (int rot = 0; rot < 2; rot++)
        for (int r = 0; r < 2; r++)
          for (int f = 0; f < 2; f++)
            for (int a = 0; a < 4; a++)
              for (int d = 0; d < 256; d++) begin
                @(negedge clk);
                data_i = d[7:0];
                amt_i = a[1:0];
                dir_right_i = r[0];
                rotate_i = rot[0];
                fill_i = f[0];
                en_i = e[0];
                // R8: no clock edge between drive and sample
                #(CLK_PERIOD/4);
                exp = ref_out(d, a, r[0], rot[0], f[0], e[0]);
                if (e == 0)      tag = "R7";
                else if (a == 0) tag = "R1";
                else if (rot)    tag = r ? "R6,R3" : "R6,R2";
                else             tag = r ? "R5,R3" : "R4,R2";
                applied++;
                if (data_o !== exp) begin
                  miscompares++;
                  $display("FAIL %s d=%h a=%0d r=%0d rot=%0d f=%0d: got %h exp %h",
                           tag, d[7:0], a, r, rot, f, data_o, exp);
                end
              end

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule